// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is an up-counting interval timer with a register width set by a parameter (8 bits by default). Software writes a compare value and a mode word, then starts the timer. On every tick of the chosen count source the counter advances by one. When the counter already equals the compare value at a tick, the counter returns to zero instead of advancing, and a sticky request flag is raised. The flag stays set until software writes a zero to clear it. The interval is therefore the compare value plus one ticks.

The count source can be one of four: the system clock, the system clock divided by four, an external clock whose rising edges are detected directly, or an external clock resynchronised through a flop chain before edge detection. A small single-cycle register bus reads and writes the mode word, the compare value and the flag, and reads the counter. The resynchronised source is the one to use when software reads the counter while an external clock is running.

Top module: `itmr_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the mode word, compare value, counter and flag are all zero, and every bus address reads 0.
- R2: Address 0 holds the mode word: bit 0 enables counting, bits 2:1 choose the source (0 system clock, 1 system clock divided by 4, 2 direct external edges, 3 resynchronised external edges), and bit 3 chooses the mode (0 interval timing, 1 counting halted). It reads back in bits 3:0, and bits 7:4 read as zero.
- R3: A mode write that sets bit 0 while bit 0 is clear forces the counter to 0 at that edge. With source 0, the counter then rises by one at every following clock edge.
- R4: At a tick where the counter equals the compare value (address 1), the counter goes to 0 and the flag (address 3, bit 0) is set. The counter therefore repeats with a period of compare+1 ticks.
- R5: If the compare value is written below the current count while running, the counter keeps counting through 8'hFF, wraps to 0 without setting the flag, and matches only when it next reaches the compare value.
- R6: A compare write while the timer is stopped leaves the counter unchanged until the next tick of the selected source, and at that tick the counter becomes 0.
- R7: The counter holds its value while bit 0 of the mode word is 0, or while bit 3 is 1, with no compare write pending.
- R8: With source 1, the counter advances exactly once in every four system-clock cycles.
- R9: With source 2, each rising edge of ext_clk advances the counter once, at the first system-clock edge that samples ext_clk high.
- R10: With source 3, each rising edge of ext_clk advances the counter once, two system-clock edges later than it would with source 2.
- R11: The flag is sticky. A bus write of 0 in bit 0 to address 3 clears it, a write of 1 has no effect, and a match in the same cycle as a clearing write leaves the flag set.
- R12: The counter address (2) is read-only. Writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk | input | 1 | External count clock |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_addr | input | 2 | Register address: 0 mode, 1 compare, 2 counter, 3 flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Sticky match request flag |

## Verification
The hardest cases to reach are the run past a compare value that is already behind the count, and a compare write during a stop whose effect must wait for the next tick. For the run-past case, the bench starts from a large compare value, counts a few steps, drops the compare value below the count, and follows the counter through the wrap to the late match. For the stop case, the bench stops the timer with the direct external source selected and ext_clk held low, writes the compare value, confirms the counter holds for several cycles, and then gives a single ext_clk pulse. The case where a clear write and a match fall in the same cycle is reached by setting the compare value to zero, so that a match happens at every edge.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  typedef enum logic [1:0] {
    SRC_SYS    = 2'd0,
    SRC_DIV4   = 2'd1,
    SRC_EXTRAW = 2'd2,
    SRC_EXTSYN = 2'd3
  } itmr_src_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  localparam int MODE_BITS = 4;

  // counter value after a tick while running
  function automatic logic [7:0] itmr_advance(input logic [7:0] cur, input logic [7:0] cmp);
    if (cur == cmp) return 8'd0;
    return cur + 8'd1;
  endfunction

  function automatic logic itmr_match(input logic [7:0] cur, input logic [7:0] cmp);
    return cur == cmp;
  endfunction

endpackage

// File: rtl/itmr_prescale.sv
module itmr_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  assign tick = (phase_q == LAST);
endmodule

// File: rtl/itmr_clksel.sv
module itmr_clksel #(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_DIV     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_clk,
  input  logic [1:0] src,
  output logic       tick
);
  import itmr_pkg::*;

  logic div_tick;
  logic raw_q;
  logic raw_tick;
  logic [SYNC_STAGES:0] sync_q;
  logic syn_tick;

  itmr_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (div_tick)
  );

  // direct edge detect
  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= 1'b0;
    else raw_q <= ext_clk;
  end
  assign raw_tick = ext_clk & ~raw_q;

  // resynchronising chain plus one edge-detect stage
  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else sync_q[0] <= ext_clk;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate
  assign syn_tick = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_comb begin
    unique case (itmr_src_e'(src))
      SRC_SYS:    tick = 1'b1;
      SRC_DIV4:   tick = div_tick;
      SRC_EXTRAW: tick = raw_tick;
      SRC_EXTSYN: tick = syn_tick;
      default:    tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/itmr_regs.sv
module itmr_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] cnt,
  input  logic          hit,
  output logic          en,
  output logic          halt_mode,
  output logic [1:0]    src,
  output logic [DW-1:0] cmp,
  output logic          flag,
  output logic          start,
  output logic          clr_req,
  output logic          cmp_wr,
  output logic [DW-1:0] rdata
);
  import itmr_pkg::*;

  logic [MODE_BITS-1:0] mode_q;
  logic [DW-1:0]        cmp_q;
  logic                 flag_q;
  logic                 mode_wr;

  assign mode_wr = bus_wr && (bus_addr == ADDR_MODE);
  assign cmp_wr  = bus_wr && (bus_addr == ADDR_CMP);
  assign clr_req = bus_wr && (bus_addr == ADDR_FLAG) && !bus_wdata[0];
  assign start   = mode_wr && bus_wdata[0] && !mode_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (mode_wr) mode_q <= bus_wdata[MODE_BITS-1:0];
      if (cmp_wr)  cmp_q  <= bus_wdata;
    end
  end

  // match has priority over a clearing write
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  assign en        = mode_q[0];
  assign src       = mode_q[2:1];
  assign halt_mode = mode_q[3];
  assign cmp       = cmp_q;
  assign flag      = flag_q;

  always_comb begin
    unique case (bus_addr)
      ADDR_MODE: rdata = DW'(mode_q);
      ADDR_CMP:  rdata = cmp_q;
      ADDR_CNT:  rdata = cnt;
      ADDR_FLAG: rdata = DW'(flag_q);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          start,
  input  logic          cmp_wr,
  input  logic [DW-1:0] cmp,
  output logic [DW-1:0] cnt,
  output logic          hit,
  output logic          pend
);
  import itmr_pkg::*;

  logic [DW-1:0] cnt_q;
  logic          pend_q;

  assign hit = run && tick && (cnt_q == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (run) begin
      if (tick) cnt_q <= (cnt_q == cmp) ? '0 : cnt_q + 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (tick && pend_q) begin
        cnt_q  <= '0;
        pend_q <= cmp_wr;
      end else if (cmp_wr) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign cnt  = cnt_q;
  assign pend = pend_q;
endmodule

// File: rtl/itmr_top.sv
module itmr_top #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_DIV     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_clk,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic          en;
  logic          halt_mode;
  logic [1:0]    src;
  logic [DW-1:0] cmp;
  logic [DW-1:0] cnt;
  logic          flag;
  logic          start;
  logic          clr_req;
  logic          cmp_wr;
  logic          tick;
  logic          hit;
  logic          pend;
  logic          run;

  assign run = en && !halt_mode;

  itmr_regs #(.DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cnt      (cnt),
    .hit      (hit),
    .en       (en),
    .halt_mode(halt_mode),
    .src      (src),
    .cmp      (cmp),
    .flag     (flag),
    .start    (start),
    .clr_req  (clr_req),
    .cmp_wr   (cmp_wr),
    .rdata    (bus_rdata)
  );

  itmr_clksel #(.SYNC_STAGES(SYNC_STAGES), .PRE_DIV(PRE_DIV)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_clk(ext_clk),
    .src    (src),
    .tick   (tick)
  );

  itmr_counter #(.DW(DW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .run   (run),
    .start (start),
    .cmp_wr(cmp_wr),
    .cmp   (cmp),
    .cnt   (cnt),
    .hit   (hit),
    .pend  (pend)
  );

  assign irq = flag;
endmodule

// File: rtl/itmr_top_chk.sv
module itmr_top_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          run,
  input logic          start,
  input logic          hit,
  input logic          pend,
  input logic          clr_req,
  input logic [DW-1:0] cnt,
  input logic          flag
);
  // R4
  match_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0) && flag);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !hit && !start) |=> cnt == $past(cnt) + 1'b1);

  // R7
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start && !(tick && pend)) |=> $stable(cnt));

  // R6
  pending_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start && tick && pend) |=> cnt == '0);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);

  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !hit) |=> !flag);
endmodule

bind itmr_top itmr_top_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .run    (run),
  .start  (start),
  .hit    (hit),
  .pend   (pend),
  .clr_req(clr_req),
  .cnt    (cnt),
  .flag   (flag)
);

// File: tb/itmr_top_test.sv
module itmr_top_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int total = 0;
  int bad = 0;

  itmr_top uut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    total++;
    if (bus_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic t_reset;
    expect_reg("R1", 2'd0, 8'h00);
    expect_reg("R1", 2'd1, 8'h00);
    expect_reg("R1", 2'd2, 8'h00);
    expect_reg("R1", 2'd3, 8'h00);
  endtask

  task automatic t_mode_rb;
    wr(2'd0, 8'hFF);
    expect_reg("R2", 2'd0, 8'h0F);
    step(5);
    expect_reg("R7", 2'd2, 8'h00); // halt mode bit set
    wr(2'd0, 8'h00);
  endtask

  task automatic t_start_run;
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h01);
    expect_reg("R3", 2'd2, 8'h00);
    step(6);
    expect_reg("R3", 2'd2, 8'h06);
    wr(2'd0, 8'h00);             // old run still counts at this edge
    expect_reg("R7", 2'd2, 8'h07);
    step(10);
    expect_reg("R7", 2'd2, 8'h07);
  endtask

  task automatic t_cnt_ro;
    wr(2'd2, 8'h55);
    step(3);
    expect_reg("R12", 2'd2, 8'h07);
  endtask

  task automatic t_stop_cmp;
    wr(2'd0, 8'h04);             // source 2, stopped
    wr(2'd1, 8'h20);
    step(5);
    expect_reg("R6", 2'd2, 8'h07);
    ext_clk = 1'b1;
    step(1);
    expect_reg("R6", 2'd2, 8'h00);
    ext_clk = 1'b0;
    step(2);
  endtask

  task automatic t_match;
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h01);
    step(4);
    expect_reg("R4", 2'd2, 8'h04);
    expect_reg("R4", 2'd3, 8'h00);
    step(1);
    expect_reg("R4", 2'd2, 8'h00);
    expect_reg("R4", 2'd3, 8'h01);
    step(5);
    expect_reg("R4", 2'd2, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_flag;
    wr(2'd3, 8'h01);
    expect_reg("R11", 2'd3, 8'h01);
    wr(2'd3, 8'h00);
    expect_reg("R11", 2'd3, 8'h00);
    total++;
    if (irq !== 1'b0) begin bad++; $display("FAIL R11 irq actual=%b expected=0", irq); end
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);
    step(2);
    wr(2'd3, 8'h00);             // match every edge, set wins
    expect_reg("R11", 2'd3, 8'h01);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h00);
    expect_reg("R11", 2'd3, 8'h00);
  endtask

  task automatic t_wrap;
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h01);
    step(10);
    wr(2'd1, 8'h03);             // count goes 10 -> 11 at this edge
    expect_reg("R5", 2'd2, 8'h0B);
    step(245);
    expect_reg("R5", 2'd2, 8'h00);
    expect_reg("R5", 2'd3, 8'h00);
    step(3);
    expect_reg("R5", 2'd2, 8'h03);
    expect_reg("R5", 2'd3, 8'h00);
    step(1);
    expect_reg("R5", 2'd2, 8'h00);
    expect_reg("R5", 2'd3, 8'h01);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_div4;
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h03);
    step(40);
    expect_reg("R8", 2'd2, 8'h0A);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_raw;
    wr(2'd0, 8'h05);
    step(3);
    expect_reg("R9", 2'd2, 8'h00);
    ext_clk = 1'b1;
    step(1);
    expect_reg("R9", 2'd2, 8'h01);
    step(2);
    expect_reg("R9", 2'd2, 8'h01);
    ext_clk = 1'b0;
    step(2);
    ext_clk = 1'b1;
    step(1);
    expect_reg("R9", 2'd2, 8'h02);
    ext_clk = 1'b0;
    step(3);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_sync;
    wr(2'd0, 8'h07);
    step(3);
    ext_clk = 1'b1;
    step(2);
    expect_reg("R10", 2'd2, 8'h00);
    step(1);
    expect_reg("R10", 2'd2, 8'h01);
    step(3);
    ext_clk = 1'b0;
    step(3);
    ext_clk = 1'b1;
    step(3);
    ext_clk = 1'b0;
    step(4);
    expect_reg("R10", 2'd2, 8'h02);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_mode_rb();
    t_start_run();
    t_cnt_ro();
    t_stop_cmp();
    t_match();
    t_flag();
    t_wrap();
    t_div4();
    t_raw();
    t_sync();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule